// File: doc/BRIEF.md
# Packet Queue Interrupt Controller

This block keeps the packet-number queues that sit between a host driver and a network MAC engine. It raises one interrupt line from the state of those queues. The host enqueues buffer numbers for transmission, and the transmit engine takes them from the head of that queue whenever it is ready. No host register read is needed between packets. When the engine finishes a packet it reports the number, a 16-bit status word and two flags (success, fatal). The result then goes either into a completion queue that the host drains, or, for successful packets in auto-release mode, straight out on a release strobe to the buffer allocator. The receive engine pushes the numbers of received packets into a receive queue, and the host drains that queue at its own pace.

Auto-release changes how interrupts are paced. With auto-release clear, every packet produces a completion entry, so the host can service one interrupt per packet. With it set, only failures are queued, and the transmit-empty status signals the end of a whole batch. A fatal error is always queued and halts the transmit queue until the host restarts it.

Top module: `pktq_irq_ctrl`

## Requirements
- R1: After reset all three queues are empty, `int_status` is 0, `irq` is 0, `eng_txq_valid` is 0 and `rel_valid` is 0. The mask register is 0.
- R2: Numbers pushed with `host_txq_push` are presented on `eng_txq_pnum` in push order. `eng_txq_valid` is high when the transmit queue is non-empty and not halted. An `eng_txq_pop` pulse removes the head only while `eng_txq_valid` is high.
- R3: `int_status[0]` is high exactly when the receive queue is non-empty. `rxq_head_pnum` shows its oldest entry without removing it, and `host_rxq_pop` removes it.
- R4: `int_status[1]` is high exactly when the completion queue is non-empty.
- R5: With `auto_rel` low, every `eng_done` pushes its number and status word into the completion queue in completion order. `cq_head_pnum` and `cq_head_stat` show the oldest entry, and `host_cq_pop` removes it.
- R6: With `auto_rel` high, a done with `eng_done_ok` high and `eng_done_fatal` low is not queued. Instead `rel_valid` pulses for one cycle, one clock after the done, with `rel_pnum` equal to the packet number. A done that is not ok is queued as in R5.
- R7: A done with `eng_done_fatal` high is queued regardless of `auto_rel`, and from the next cycle `eng_txq_valid` stays low until a `host_restart` pulse.
- R8: `int_status[2]` (transmit empty) is set one clock after a done that arrives while the transmit queue is empty. It is cleared by `host_ack[2]` or by a `host_txq_push`.
- R9: `irq` is the OR of `int_status & mask`, where the 4-bit mask is loaded from `host_mask_d` on `host_mask_we`.
- R10: A pop of an empty completion or receive queue is ignored. The queue stays empty, and its head output reads 0 while the queue is empty.
- R11: A push into a full queue (32 entries) drops the entry and sets the sticky `int_status[3]`. Only `host_ack[3]` clears that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| auto_rel | input | 1 | Auto-release mode |
| host_txq_push | input | 1 | Host enqueue strobe |
| host_txq_pnum | input | 6 | Packet number to enqueue |
| host_cq_pop | input | 1 | Pop completion queue head |
| host_rxq_pop | input | 1 | Pop receive queue head |
| host_mask_we | input | 1 | Mask register write strobe |
| host_mask_d | input | 4 | Mask write data |
| host_ack | input | 4 | Write-one-to-clear: bit 2 transmit empty, bit 3 overflow |
| host_restart | input | 1 | Resume transmit after a fatal error |
| cq_head_pnum | output | 6 | Completion queue head number |
| cq_head_stat | output | 16 | Completion queue head status word |
| rxq_head_pnum | output | 6 | Receive queue head number |
| int_status | output | 4 | {overflow, tx empty, completion pending, rx pending} |
| irq | output | 1 | Interrupt request |
| eng_txq_valid | output | 1 | A packet is available to transmit |
| eng_txq_pnum | output | 6 | Next packet to transmit |
| eng_txq_pop | input | 1 | Engine takes the head |
| eng_done | input | 1 | Transmit finished strobe |
| eng_done_pnum | input | 6 | Finished packet number |
| eng_done_stat | input | 16 | Finished packet status word |
| eng_done_ok | input | 1 | Transmit succeeded |
| eng_done_fatal | input | 1 | Fatal transmit error |
| eng_rx_push | input | 1 | Received packet strobe |
| eng_rx_pnum | input | 6 | Received packet number |
| rel_valid | output | 1 | Release strobe to allocator |
| rel_pnum | output | 6 | Number being released |

## Verification
Every queue, status and halt effect is registered, so each one shows up one clock after the edge that samples the stimulus. The release strobe is also due one clock after the done. `irq` follows the registered status and mask in the same cycle. The bench drives every input on a falling edge, lets exactly one rising edge pass, and samples on the next falling edge, so each check lands in the cycle where its result is due. Before stepping further it also confirms that the one-cycle release pulse has dropped again.

// File: rtl/pktq_irq_ctrl.sv
module pktq_irq_ctrl #(
  parameter int PNUM_W = 6,
  parameter int STAT_W = 16,
  parameter int DEPTH  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_rel,
  input  logic              host_txq_push,
  input  logic [PNUM_W-1:0] host_txq_pnum,
  input  logic              host_cq_pop,
  input  logic              host_rxq_pop,
  input  logic              host_mask_we,
  input  logic [3:0]        host_mask_d,
  input  logic [3:0]        host_ack,
  input  logic              host_restart,
  output logic [PNUM_W-1:0] cq_head_pnum,
  output logic [STAT_W-1:0] cq_head_stat,
  output logic [PNUM_W-1:0] rxq_head_pnum,
  output logic [3:0]        int_status,
  output logic              irq,
  output logic              eng_txq_valid,
  output logic [PNUM_W-1:0] eng_txq_pnum,
  input  logic              eng_txq_pop,
  input  logic              eng_done,
  input  logic [PNUM_W-1:0] eng_done_pnum,
  input  logic [STAT_W-1:0] eng_done_stat,
  input  logic              eng_done_ok,
  input  logic              eng_done_fatal,
  input  logic              eng_rx_push,
  input  logic [PNUM_W-1:0] eng_rx_pnum,
  output logic              rel_valid,
  output logic [PNUM_W-1:0] rel_pnum
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  // transmit queue
  logic [PNUM_W-1:0] txq_mem [DEPTH];
  logic [PTR_W-1:0]  txq_wp, txq_rp;
  logic [CNT_W-1:0]  txq_cnt;
  logic              halted;
  logic              txq_full, txq_push_ok, txq_pop_ok;

  assign txq_full      = (txq_cnt == FULL);
  assign txq_push_ok   = host_txq_push & ~txq_full;
  assign eng_txq_valid = (txq_cnt != '0) & ~halted;
  assign txq_pop_ok    = eng_txq_pop & eng_txq_valid;
  assign eng_txq_pnum  = (txq_cnt != '0) ? txq_mem[txq_rp] : '0;

  always_ff @(posedge clk) if (txq_push_ok) txq_mem[txq_wp] <= host_txq_pnum;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txq_wp <= '0; txq_rp <= '0; txq_cnt <= '0;
    end else begin
      if (txq_push_ok) txq_wp <= txq_wp + 1'b1;
      if (txq_pop_ok)  txq_rp <= txq_rp + 1'b1;
      case ({txq_push_ok, txq_pop_ok})
        2'b10:   txq_cnt <= txq_cnt + 1'b1;
        2'b01:   txq_cnt <= txq_cnt - 1'b1;
        default: txq_cnt <= txq_cnt;
      endcase
    end
  end

  // completion routing
  logic do_release, cq_req;
  assign do_release = eng_done & auto_rel & eng_done_ok & ~eng_done_fatal;
  assign cq_req     = eng_done & ~do_release;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rel_valid <= 1'b0; rel_pnum <= '0;
    end else begin
      rel_valid <= do_release;
      if (do_release) rel_pnum <= eng_done_pnum;
    end
  end

  // completion queue
  logic [PNUM_W-1:0] cq_pn_mem [DEPTH];
  logic [STAT_W-1:0] cq_st_mem [DEPTH];
  logic [PTR_W-1:0]  cq_wp, cq_rp;
  logic [CNT_W-1:0]  cq_cnt;
  logic              cq_full, cq_push_ok, cq_pop_ok;

  assign cq_full      = (cq_cnt == FULL);
  assign cq_push_ok   = cq_req & ~cq_full;
  assign cq_pop_ok    = host_cq_pop & (cq_cnt != '0);
  assign cq_head_pnum = (cq_cnt != '0) ? cq_pn_mem[cq_rp] : '0;
  assign cq_head_stat = (cq_cnt != '0) ? cq_st_mem[cq_rp] : '0;

  always_ff @(posedge clk) begin
    if (cq_push_ok) begin
      cq_pn_mem[cq_wp] <= eng_done_pnum;
      cq_st_mem[cq_wp] <= eng_done_stat;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cq_wp <= '0; cq_rp <= '0; cq_cnt <= '0;
    end else begin
      if (cq_push_ok) cq_wp <= cq_wp + 1'b1;
      if (cq_pop_ok)  cq_rp <= cq_rp + 1'b1;
      case ({cq_push_ok, cq_pop_ok})
        2'b10:   cq_cnt <= cq_cnt + 1'b1;
        2'b01:   cq_cnt <= cq_cnt - 1'b1;
        default: cq_cnt <= cq_cnt;
      endcase
    end
  end

  // receive queue
  logic [PNUM_W-1:0] rxq_mem [DEPTH];
  logic [PTR_W-1:0]  rxq_wp, rxq_rp;
  logic [CNT_W-1:0]  rxq_cnt;
  logic              rxq_full, rxq_push_ok, rxq_pop_ok;

  assign rxq_full      = (rxq_cnt == FULL);
  assign rxq_push_ok   = eng_rx_push & ~rxq_full;
  assign rxq_pop_ok    = host_rxq_pop & (rxq_cnt != '0);
  assign rxq_head_pnum = (rxq_cnt != '0) ? rxq_mem[rxq_rp] : '0;

  always_ff @(posedge clk) if (rxq_push_ok) rxq_mem[rxq_wp] <= eng_rx_pnum;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxq_wp <= '0; rxq_rp <= '0; rxq_cnt <= '0;
    end else begin
      if (rxq_push_ok) rxq_wp <= rxq_wp + 1'b1;
      if (rxq_pop_ok)  rxq_rp <= rxq_rp + 1'b1;
      case ({rxq_push_ok, rxq_pop_ok})
        2'b10:   rxq_cnt <= rxq_cnt + 1'b1;
        2'b01:   rxq_cnt <= rxq_cnt - 1'b1;
        default: rxq_cnt <= rxq_cnt;
      endcase
    end
  end

  // status, mask, halt
  logic       txe, ovf;
  logic [3:0] mask;
  logic       ovf_set;

  assign ovf_set = (host_txq_push & txq_full) | (cq_req & cq_full) | (eng_rx_push & rxq_full);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txe <= 1'b0; ovf <= 1'b0; mask <= '0; halted <= 1'b0;
    end else begin
      if (host_ack[2] | host_txq_push) txe <= 1'b0;
      else if (eng_done & (txq_cnt == '0)) txe <= 1'b1;
      if (ovf_set) ovf <= 1'b1;
      else if (host_ack[3]) ovf <= 1'b0;
      if (host_mask_we) mask <= host_mask_d;
      if (eng_done & eng_done_fatal) halted <= 1'b1;
      else if (host_restart) halted <= 1'b0;
    end
  end

  assign int_status = {ovf, txe, (cq_cnt != '0), (rxq_cnt != '0)};
  assign irq        = |(int_status & mask);

  // assertions
  p_rel_auto_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> $past(eng_done & auto_rel & eng_done_ok & ~eng_done_fatal));

  p_fatal_halts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done & eng_done_fatal) |=> !eng_txq_valid);

  p_fatal_queued_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done & eng_done_fatal & !cq_full & !host_cq_pop) |=> (cq_cnt == $past(cq_cnt) + 1'b1));

  p_txe_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    host_txq_push |=> !int_status[2]);

  p_mask_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_mask_we & (host_mask_d == 4'd0)) |=> !irq);

  p_rx_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_rx_push & !host_rxq_pop) |=> int_status[0]);

  p_pop_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((rxq_cnt == '0) & host_rxq_pop & !eng_rx_push) |=> (rxq_cnt == '0));

  p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (int_status[3] & !host_ack[3]) |=> int_status[3]);

  p_pop_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_txq_pop & !eng_txq_valid & !host_txq_push) |=> (txq_cnt == $past(txq_cnt)));

endmodule

// File: tb/sim_pktq_irq_ctrl.sv
module sim_pktq_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic auto_rel = 0, host_txq_push = 0, host_cq_pop = 0, host_rxq_pop = 0;
  logic host_mask_we = 0, host_restart = 0;
  logic [5:0] host_txq_pnum = 0;
  logic [3:0] host_mask_d = 0, host_ack = 0;
  logic [5:0] cq_head_pnum, rxq_head_pnum, eng_txq_pnum, rel_pnum;
  logic [15:0] cq_head_stat;
  logic [3:0] int_status;
  logic irq, eng_txq_valid, rel_valid;
  logic eng_txq_pop = 0, eng_done = 0, eng_done_ok = 0, eng_done_fatal = 0, eng_rx_push = 0;
  logic [5:0] eng_done_pnum = 0, eng_rx_pnum = 0;
  logic [15:0] eng_done_stat = 0;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pktq_irq_ctrl u0 (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic host_push(input logic [5:0] p);
    host_txq_push = 1; host_txq_pnum = p; step(); host_txq_push = 0;
  endtask

  task automatic eng_pop();
    eng_txq_pop = 1; step(); eng_txq_pop = 0;
  endtask

  task automatic done(input logic [5:0] p, input logic [15:0] s, input logic ok, input logic fatal);
    eng_done = 1; eng_done_pnum = p; eng_done_stat = s; eng_done_ok = ok; eng_done_fatal = fatal;
    step(); eng_done = 0; eng_done_ok = 0; eng_done_fatal = 0;
  endtask

  task automatic cq_pop(); host_cq_pop = 1; step(); host_cq_pop = 0; endtask
  task automatic rx_pop(); host_rxq_pop = 1; step(); host_rxq_pop = 0; endtask
  task automatic ack(input logic [3:0] a); host_ack = a; step(); host_ack = 0; endtask
  task automatic set_mask(input logic [3:0] m); host_mask_we = 1; host_mask_d = m; step(); host_mask_we = 0; endtask

  task automatic t_reset();
    check("R1 status", int_status, 0);
    check("R1 irq", irq, 0);
    check("R1 txq_valid", eng_txq_valid, 0);
    check("R1 rel_valid", rel_valid, 0);
  endtask

  task automatic t_tx_order();
    host_push(6'd5); host_push(6'd9); host_push(6'd17);
    check("R2 valid", eng_txq_valid, 1);
    check("R2 head0", eng_txq_pnum, 5);
    eng_pop(); check("R2 head1", eng_txq_pnum, 9);
    eng_pop(); check("R2 head2", eng_txq_pnum, 17);
    eng_pop(); check("R2 drained", eng_txq_valid, 0);
  endtask

  task automatic t_completion();
    done(6'd5, 16'h1234, 1, 0);
    check("R4 pending", int_status[1], 1);
    check("R8 txe set", int_status[2], 1);
    done(6'd9, 16'hA00F, 0, 0);
    done(6'd17, 16'h0042, 1, 0);
    check("R5 head0 pn", cq_head_pnum, 5);
    check("R5 head0 st", cq_head_stat, 16'h1234);
    cq_pop(); check("R5 head1 pn", cq_head_pnum, 9);
    check("R5 head1 st", cq_head_stat, 16'hA00F);
    cq_pop(); check("R5 head2 pn", cq_head_pnum, 17);
    cq_pop(); check("R4 empty", int_status[1], 0);
    cq_pop(); check("R10 cq stays empty", int_status[1], 0);
    check("R10 cq head zero", cq_head_pnum, 0);
    check("R9 masked", irq, 0);
    set_mask(4'b0100); check("R9 irq txe", irq, 1);
    ack(4'b0100); check("R8 ack clears", int_status[2], 0);
    check("R9 irq drop", irq, 0);
  endtask

  task automatic t_auto_release();
    auto_rel = 1;
    host_push(6'd20); eng_pop();
    done(6'd20, 16'h0001, 1, 0);
    check("R6 rel_valid", rel_valid, 1);
    check("R6 rel_pnum", rel_pnum, 20);
    check("R6 not queued", int_status[1], 0);
    check("R8 txe batch", int_status[2], 1);
    step(); check("R6 pulse ends", rel_valid, 0);
    done(6'd21, 16'h0BAD, 0, 0);
    check("R6 fail queued", cq_head_pnum, 21);
    check("R6 no release", rel_valid, 0);
    cq_pop();
    host_push(6'd30);
    check("R8 push clears", int_status[2], 0);
  endtask

  task automatic t_fatal();
    host_push(6'd31); eng_pop();
    done(6'd30, 16'hDEAD, 0, 1);
    check("R7 queued", cq_head_pnum, 30);
    check("R7 stat", cq_head_stat, 16'hDEAD);
    check("R7 halted", eng_txq_valid, 0);
    eng_pop(); check("R7 pop ignored", eng_txq_pnum, 31);
    host_restart = 1; step(); host_restart = 0;
    check("R7 restart", eng_txq_valid, 1);
    check("R2 head kept", eng_txq_pnum, 31);
    eng_pop(); cq_pop(); auto_rel = 0;
  endtask

  task automatic t_rx();
    eng_rx_push = 1; eng_rx_pnum = 6'd3; step();
    eng_rx_pnum = 6'd4; step(); eng_rx_push = 0;
    check("R3 pending", int_status[0], 1);
    check("R3 head", rxq_head_pnum, 3);
    set_mask(4'b0001); check("R9 rx irq", irq, 1);
    rx_pop(); check("R3 head2", rxq_head_pnum, 4);
    rx_pop(); check("R3 empty", int_status[0], 0);
    check("R9 irq off", irq, 0);
    rx_pop(); check("R10 rx stays empty", int_status[0], 0);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 33; i++) begin
      eng_rx_push = 1; eng_rx_pnum = 6'(i); step();
    end
    eng_rx_push = 0;
    check("R11 ovf set", int_status[3], 1);
    set_mask(4'b1000); check("R9 ovf irq", irq, 1);
    for (int i = 0; i < 32; i++) begin
      check("R11 entry", rxq_head_pnum, 32'(i));
      rx_pop();
    end
    check("R11 dropped", int_status[0], 0);
    check("R11 sticky", int_status[3], 1);
    ack(4'b1000); check("R11 cleared", int_status[3], 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(); step(); rst_n = 1; step();
    t_reset();
    t_tx_order();
    t_completion();
    t_auto_release();
    t_fatal();
    t_rx();
    t_overflow();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule